// File: doc/BRIEF.md
# SDRAM Auto-Refresh Timer and Sequencer

This block decides when an SDRAM needs refreshing and drives the refresh command sequence on the command bus. A free-running prescaler divides the core clock by a power of four, chosen by a 3-bit clock-select field. Each prescaled tick advances an up-counter. The counter is compared with a programmable refresh constant. When the count equals the constant, the counter returns to zero and, if refreshing is enabled and auto mode is selected, a refresh burst is requested.

A burst holds the bus through a busy/grant handshake with the arbiter. Once the grant arrives, the burst runs a decoded number of refresh operations back to back. Each operation is a precharge-all cycle, a programmable gap of NOP cycles, a refresh cycle, and then a programmable lockout filled with NOPs. A match that comes while a burst is already running is dropped. Configuration is written through a small register port. Address and data paths are not part of this block.

Top module: `sdram_refresh_ctrl`

## Requirements
- R1: Clock-select value 0 stops the refresh counter. A value s from 1 to 7 produces one counter tick every 4^(s-1) clock cycles. The control word at address 0 holds clock-select in bits [2:0], the burst-count field in bits [5:3], the enable bit in bit 6 and the auto-mode bit in bit 7.
- R2: A value written to address 2 loads the counter. Selecting a clock source afterwards continues counting from that value and does not clear it.
- R3: On a tick where the counter equals the constant written at address 1, a match occurs and the counter becomes 0 in the same step. Matches therefore repeat every constant+1 ticks.
- R4: A match starts a burst only while both the enable bit and the auto-mode bit are 1. Matches that occur while either bit is 0 are discarded and are not remembered.
- R5: Busy rises in the cycle after an accepted match, and the command stays NOP until the grant is seen. The precharge-all command (code 1) is issued in the cycle after a clock edge that samples the grant high.
- R6: The burst-count field selects 1, 2, 4, 6, 8, 10, 12 or 16 refresh operations for the values 0 to 7.
- R7: Bits [1:0] at address 3 select a gap of 1 to 4 NOP cycles (values 0 to 3) between the precharge-all and the refresh command (code 2).
- R8: Bits [3:2] at address 3 select a lockout of 1 to 4 cycles (values 0 to 3) after each refresh command. Only NOP (code 0) is issued during the lockout. The next operation of the same burst begins with precharge-all right after the lockout.
- R9: Busy falls in the cycle after the last lockout cycle of the burst.
- R10: After reset, busy is 0, the command is NOP and the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Register select: 0 control, 1 constant, 2 counter load, 3 timing |
| cfg_wdata_i | input | DATA_W | Write data |
| rfsh_grant_i | input | 1 | Bus grant from the arbiter |
| rfsh_busy_o | output | 1 | Refresh burst holds or requests the bus |
| sdram_cmd_o | output | 2 | Command: 0 NOP, 1 precharge-all, 2 refresh |

## Verification
The hardest situation to reach is a single burst running with known, isolated timing. The counter keeps matching in the background, so a second match could start another burst or overlap the one being traced. For every combination of burst count, gap and lockout, the bench first disables refreshing and loads the counter one step below a large constant. It then enables refreshing so that exactly one match fires two ticks later. The burst is traced cycle by cycle against a schedule computed arithmetically, and refreshing is disabled again long before the counter can wrap.

// File: rtl/sdram_rfsh_pkg.sv
package sdram_rfsh_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PALL = 2'd1,
        CMD_REF  = 2'd2
    } rfsh_cmd_e;

    typedef struct packed {
        logic       auto_mode;
        logic       enable;
        logic [2:0] burst_sel;
        logic [2:0] clk_sel;
    } rfsh_ctrl_t;

    typedef struct packed {
        logic [1:0] trc_sel;
        logic [1:0] trp_sel;
    } rfsh_timing_t;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_LIMIT  = 2'd1;
    localparam logic [1:0] ADDR_COUNT  = 2'd2;
    localparam logic [1:0] ADDR_TIMING = 2'd3;

    localparam int BURST_W = 5;

    function automatic logic [BURST_W-1:0] burst_decode(input logic [2:0] sel);
        logic [BURST_W-1:0] n;
        if (sel == 3'd0)      n = 5'd1;
        else if (sel == 3'd7) n = 5'd16;
        else                  n = {1'b0, sel, 1'b0};
        return n;
    endfunction

endpackage

// File: rtl/rfsh_prescaler.sv
module rfsh_prescaler #(
    parameter int PRE_SHIFT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel_i,
    output logic       tick_o
);
    localparam int PRE_W = PRE_SHIFT * 6;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_q, st_d;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < PRE_SHIFT * (int'(clk_sel_i) - 1)) mask[i] = 1'b1;
        end
    end

    assign tick_o = (clk_sel_i != 3'd0) && ((st_q.cnt & mask) == mask);

    always_comb begin
        st_d = st_q;
        if (clk_sel_i != 3'd0) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             match_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_q, st_d;

    assign match_o = tick_i && !load_i && (st_q.cnt == limit_i);

    always_comb begin
        st_d = st_q;
        if (load_i)       st_d.cnt = load_val_i;
        else if (match_o) st_d.cnt = '0;
        else if (tick_i)  st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_clear_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> (st_q.cnt == '0));

    assert_hold_without_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/rfsh_sequencer.sv
module rfsh_sequencer
    import sdram_rfsh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       grant_i,
    input  logic [2:0] burst_sel_i,
    input  logic [1:0] trp_sel_i,
    input  logic [1:0] trc_sel_i,
    output logic       busy_o,
    output rfsh_cmd_e  cmd_o
);
    typedef enum logic [2:0] {
        S_IDLE, S_GNT, S_PALL, S_TRP, S_REF, S_TRC
    } seq_state_e;

    typedef struct packed {
        seq_state_e         state;
        logic [1:0]         wait_cnt;
        logic [BURST_W-1:0] remain;
    } seq_t;

    seq_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            S_IDLE: if (req_i) begin
                st_d.state  = S_GNT;
                st_d.remain = burst_decode(burst_sel_i) - 1'b1;
            end
            S_GNT: if (grant_i) st_d.state = S_PALL;
            S_PALL: begin
                st_d.state    = S_TRP;
                st_d.wait_cnt = trp_sel_i;
            end
            S_TRP: begin
                if (st_q.wait_cnt == 2'd0) st_d.state = S_REF;
                else st_d.wait_cnt = st_q.wait_cnt - 1'b1;
            end
            S_REF: begin
                st_d.state    = S_TRC;
                st_d.wait_cnt = trc_sel_i;
            end
            S_TRC: begin
                if (st_q.wait_cnt != 2'd0) begin
                    st_d.wait_cnt = st_q.wait_cnt - 1'b1;
                end else if (st_q.remain == '0) begin
                    st_d.state = S_IDLE;
                end else begin
                    st_d.remain = st_q.remain - 1'b1;
                    st_d.state  = S_PALL;
                end
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: S_IDLE, wait_cnt: 2'd0, remain: '0};
        else        st_q <= st_d;
    end

    assign busy_o = (st_q.state != S_IDLE);

    always_comb begin
        cmd_o = CMD_NOP;
        if (st_q.state == S_PALL)     cmd_o = CMD_PALL;
        else if (st_q.state == S_REF) cmd_o = CMD_REF;
    end

    assert_cmd_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != CMD_NOP) |-> busy_o);

    assert_pall_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PALL && $past(st_q.state) == S_GNT) |-> $past(grant_i));

    assert_gap_after_pall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PALL) |=> (cmd_o == CMD_NOP));

    assert_lockout_after_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_REF) |=> (cmd_o == CMD_NOP));

    assert_busy_ends_after_lockout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(st_q.state) == S_TRC));

endmodule

// File: rtl/sdram_refresh_ctrl.sv
module sdram_refresh_ctrl
    import sdram_rfsh_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PRE_SHIFT = 2,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic [1:0]        cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    input  logic              rfsh_grant_i,
    output logic              rfsh_busy_o,
    output logic [1:0]        sdram_cmd_o
);
    typedef struct packed {
        rfsh_ctrl_t       ctrl;
        rfsh_timing_t     timing;
        logic [CNT_W-1:0] limit;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    logic             tick;
    logic             match;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             req;
    logic             busy;
    rfsh_cmd_e        cmd;

    always_comb begin
        cfg_d    = cfg_q;
        cnt_load = 1'b0;
        cnt_val  = CNT_W'(cfg_wdata_i);
        if (cfg_wr_i) begin
            unique case (cfg_addr_i)
                ADDR_CTRL:   cfg_d.ctrl   = cfg_wdata_i[7:0];
                ADDR_LIMIT:  cfg_d.limit  = CNT_W'(cfg_wdata_i);
                ADDR_COUNT:  cnt_load     = 1'b1;
                ADDR_TIMING: cfg_d.timing = cfg_wdata_i[3:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    rfsh_prescaler #(.PRE_SHIFT(PRE_SHIFT)) i_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_sel_i (cfg_q.ctrl.clk_sel),
        .tick_o    (tick)
    );

    rfsh_timer #(.CNT_W(CNT_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .limit_i    (cfg_q.limit),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .match_o    (match)
    );

    assign req = match && cfg_q.ctrl.enable && cfg_q.ctrl.auto_mode && !busy;

    rfsh_sequencer i_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .grant_i     (rfsh_grant_i),
        .burst_sel_i (cfg_q.ctrl.burst_sel),
        .trp_sel_i   (cfg_q.timing.trp_sel),
        .trc_sel_i   (cfg_q.timing.trc_sel),
        .busy_o      (busy),
        .cmd_o       (cmd)
    );

    assign rfsh_busy_o = busy;
    assign sdram_cmd_o = cmd;

    assert_no_req_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.ctrl.enable || !cfg_q.ctrl.auto_mode) |=> !$rose(rfsh_busy_o));

endmodule

// File: tb/test_sdram_refresh_ctrl.sv
`timescale 1ns/1ps
module test_sdram_refresh_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        grant = 1'b1;
    logic        busy;
    logic [1:0]  cmd;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sdram_refresh_ctrl i_sdram_refresh_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_i     (cfg_wr),
        .cfg_addr_i   (cfg_addr),
        .cfg_wdata_i  (cfg_wdata),
        .rfsh_grant_i (grant),
        .rfsh_busy_o  (busy),
        .sdram_cmd_o  (cmd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic logic [15:0] ctrl_word(input bit au, input bit en,
                                              input int burst, input int sel);
        return {8'h00, au, en, 3'(burst), 3'(sel)};
    endfunction

    function automatic int burst_n(input int s);
        if (s == 0) return 1;
        if (s == 7) return 16;
        return 2 * s;
    endfunction

    task automatic quiesce();
        wr(2'd0, 16'h0000);
        while (busy) step();
    endtask

    task automatic rise_gap(output int n);
        n = 0;
        while (busy)  begin step(); n++; end
        while (!busy) begin step(); n++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        bit seen;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check(busy == 1'b0, "R10 busy", int'(busy), 0);
        check(cmd == 2'd0, "R10 cmd", int'(cmd), 0);
        seen = 0;
        for (int i = 0; i < 30; i++) begin step(); if (busy) seen = 1; end
        check(!seen, "R10 idle after reset", int'(seen), 0);

        // R1: counter stopped with clock-select 0 while enabled
        wr(2'd1, 16'd10);
        wr(2'd2, 16'd8);
        wr(2'd0, ctrl_word(1, 1, 0, 0));
        seen = 0;
        for (int i = 0; i < 50; i++) begin step(); if (busy) seen = 1; end
        check(!seen, "R1 clk_sel 0 stops counter", int'(seen), 0);

        // R2: selecting a source continues from the loaded value (8 -> 9 -> 10 -> match)
        wr(2'd0, ctrl_word(1, 1, 0, 1));
        n = 0;
        while (!busy && n < 40) begin step(); n++; end
        check(n == 3, "R2 resume from loaded value", n, 3);
        quiesce();

        // R3 / R1: match period in edges for prescale 1, 4, 16
        for (int s = 1; s <= 3; s++) begin
            int exp_p;
            exp_p = 41 * (1 << (2 * (s - 1)));
            wr(2'd3, 16'h0000);
            wr(2'd1, 16'd40);
            wr(2'd2, 16'd0);
            wr(2'd0, ctrl_word(1, 1, 0, s));
            rise_gap(n);
            rise_gap(n);
            check(n == exp_p, $sformatf("R3 R1 period sel=%0d", s), n, exp_p);
            quiesce();
        end

        // R4: enable or auto-mode clear discards matches
        wr(2'd1, 16'd5);
        wr(2'd0, ctrl_word(1, 0, 0, 1));
        seen = 0;
        for (int i = 0; i < 40; i++) begin step(); if (busy) seen = 1; end
        check(!seen, "R4 enable clear ignored", int'(seen), 0);
        wr(2'd0, ctrl_word(0, 1, 0, 1));
        seen = 0;
        for (int i = 0; i < 40; i++) begin step(); if (busy) seen = 1; end
        check(!seen, "R4 auto clear ignored", int'(seen), 0);
        quiesce();

        // R5: wait for grant
        grant = 1'b0;
        wr(2'd3, 16'h0000);
        wr(2'd1, 16'd200);
        wr(2'd2, 16'd199);
        wr(2'd0, ctrl_word(1, 1, 0, 1));
        n = 0;
        while (!busy && n < 20) begin step(); n++; end
        check(busy == 1'b1, "R5 busy raised", int'(busy), 1);
        wr(2'd0, 16'h0000);
        seen = 0;
        for (int i = 0; i < 8; i++) begin step(); if (cmd != 2'd0) seen = 1; end
        check(!seen, "R5 NOP while not granted", int'(seen), 0);
        grant = 1'b1;
        step();
        check(cmd == 2'd1, "R5 PALL after grant", int'(cmd), 1);
        while (busy) step();

        // R6 R7 R8 R9: sweep of burst count, gap and lockout
        for (int b = 0; b < 8; b++) begin
            for (int p = 0; p < 4; p++) begin
                for (int c = 0; c < 4; c++) begin
                    int len, nb, bad_i, act;
                    int expc;
                    nb = burst_n(b);
                    len = 2 + (p + 1) + (c + 1);
                    wr(2'd0, 16'h0000);
                    wr(2'd3, 16'((c << 2) | p));
                    wr(2'd1, 16'd200);
                    wr(2'd2, 16'd199);
                    wr(2'd0, ctrl_word(1, 1, b, 1));
                    n = 0;
                    while (!busy && n < 20) begin step(); n++; end
                    bad_i = -1; act = 0; expc = 0;
                    for (int i = 0; i < nb * len; i++) begin
                        int ph;
                        step();
                        ph = i % len;
                        expc = (ph == 0) ? 1 : ((ph == p + 2) ? 2 : 0);
                        if (bad_i < 0 && (cmd != 2'(expc) || !busy)) begin
                            bad_i = i; act = int'(cmd);
                        end
                    end
                    check(bad_i < 0,
                          $sformatf("R6 R7 R8 sequence b=%0d p=%0d c=%0d at %0d",
                                    b, p, c, bad_i), act, expc);
                    step();
                    check(busy == 1'b0, $sformatf("R9 busy end b=%0d p=%0d c=%0d", b, p, c),
                          int'(busy), 0);
                    wr(2'd0, 16'h0000);
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule